// File: doc/BRIEF.md
# Framed Serial Request/Response Engine

This block runs one request/response exchange with a remote board over a half-duplex byte link of the RS485 kind. A local requester presents a fixed 28-byte payload and pulses a start input. The engine puts the line driver on and sends a frame made of a delimiter byte, the payload and a CRC-8 byte. It then releases the line and listens for a reply frame of the same shape.

The exchange ends with a one-cycle done pulse and a status code. The code is OK when the reply checksum matches, a CRC error when it does not, and a timeout when no complete reply arrives. A missing reply causes the same frame to be sent again, at most twice. With a 50 MHz clock the defaults give 250 kbit/s, 200 clocks per bit, and a reply window of 2 ms (100000 clocks). The bit-level serializer and deserializer are internal submodules. The content of the reply is passed out without being interpreted.

Top module: `frame_xcvr`

## Requirements
- R1: While rst_ni is low, txd_o is 1, drv_en_o is 0, done_o is 0 and status_o is 0.
- R2: A transmitted frame is 30 characters: 0x40 first, then payload byte k (payload_i[8k+7:8k]) for k = 0 to 27 in increasing k, then the CRC byte. Each character is one start bit (0), eight data bits least significant first and one stop bit (1), and each bit lasts CLK_DIV clocks.
- R3: The CRC byte is CRC-8 over the 28 payload bytes, with polynomial 0x07, shifted most significant bit first, register preset to 0xFF, and no reflection or final inversion. The delimiter is not included.
- R4: drv_en_o is 1 from the first start bit until one bit time after the stop bit of the last character, and 0 otherwise. txd_o is 1 whenever drv_en_o is 0.
- R5: While it listens, the engine discards received characters until it sees 0x40. It then takes the next 28 bytes as reply bytes 0 to 27 and the byte after them as the CRC. On a CRC match it pulses done_o with status_o = 1, and reply_o holds reply byte k at bits 8k+7:8k. Bytes equal to 0x40 inside the reply are data.
- R6: On a CRC mismatch it pulses done_o with status_o = 2 and sends nothing further.
- R7: If a complete reply has not arrived TIMEOUT_CYCLES clocks after the line is released, the engine resends the frame. It resends at most MAX_RETRY times (default 2, so at most 3 frames). After the last window expires it pulses done_o with status_o = 3 and sends no further frame. Resent frames carry the payload captured at start, even if payload_i has changed since.
- R8: A valid reply that arrives after a resend completes the exchange with status_o = 1.
- R9: done_o is high for exactly one clock per exchange. status_o changes only with done_o. A start_i pulse during an exchange has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an exchange (used only when idle) |
| payload_i | input | PAYLOAD_BYTES*8 | Request payload, byte k at bits 8k+7:8k |
| txd_o | output | 1 | Serial transmit data |
| drv_en_o | output | 1 | Line driver enable |
| rxd_i | input | 1 | Serial receive data |
| done_o | output | 1 | One-cycle end-of-exchange pulse |
| status_o | output | 2 | 1 OK, 2 CRC error, 3 timeout |
| reply_o | output | PAYLOAD_BYTES*8 | Reply payload, byte k at bits 8k+7:8k |

## Verification
The bench is a remote-board model that decodes every frame on txd_o and compares it with a frame it builds itself from the payload and its own CRC. It then answers in one of several ways:
- A clean reply whose data contains 0x40 bytes shows that the delimiter search stops once a frame has started.
- A reply preceded by a junk character exercises the delimiter search.
- A corrupted CRC separates the CRC-error path from the retry path.
- No reply at all, and no reply to the first frame only, separate exhaustion of the retries from recovery on a resend.

Payloads of ramps, all zeros and all ones, together with a change of payload_i and a second start pulse during the exchange, show that the captured frame is the one resent and that a late start is ignored.

// File: rtl/frame_xcvr_pkg.sv
package frame_xcvr_pkg;
  typedef enum logic [1:0] {
    XS_NONE = 2'd0, XS_OK = 2'd1, XS_CRC_ERR = 2'd2, XS_TIMEOUT = 2'd3
  } xfer_status_e;

  typedef enum logic [1:0] {FS_IDLE, FS_SEND, FS_HOLD, FS_LISTEN} xfer_state_e;

  localparam logic [7:0] CRC_POLY = 8'h07;
  localparam logic [7:0] CRC_SEED = 8'hFF;

  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    c = crc ^ b;
    for (int i = 0; i < 8; i++) c = c[7] ? ({c[6:0], 1'b0} ^ CRC_POLY) : {c[6:0], 1'b0};
    return c;
  endfunction
endpackage

// File: rtl/frame_xcvr_tx.sv
module frame_xcvr_tx #(
  parameter int unsigned CLK_DIV = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       send_i,
  input  logic [7:0] data_i,
  output logic       txd_o,
  output logic       done_o
);
  localparam int unsigned CW = $clog2(CLK_DIV);

  logic [CW-1:0] cnt_q;
  logic [3:0]    bit_q;
  logic [9:0]    sh_q;
  logic          busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; bit_q <= '0; sh_q <= '1; busy_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (send_i) begin
          sh_q   <= {1'b1, data_i, 1'b0};
          busy_q <= 1'b1;
          cnt_q  <= CW'(CLK_DIV - 1);
          bit_q  <= '0;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
      end else begin
        cnt_q <= CW'(CLK_DIV - 1);
        sh_q  <= {1'b1, sh_q[9:1]};
        if (bit_q == 4'd9) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          bit_q <= bit_q + 4'd1;
        end
      end
    end
  end

  assign txd_o  = busy_q ? sh_q[0] : 1'b1;
  assign done_o = done_q;
endmodule

// File: rtl/frame_xcvr_rx.sv
module frame_xcvr_rx #(
  parameter int unsigned CLK_DIV = 200
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rxd_i,
  output logic       valid_o,
  output logic [7:0] data_o
);
  localparam int unsigned CW   = $clog2(CLK_DIV);
  localparam int unsigned HALF = CLK_DIV / 2 - 1;

  logic [1:0]    sync_q;
  logic          rx;
  logic          busy_q, valid_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    bit_q;
  logic [7:0]    sh_q;

  assign rx = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11; busy_q <= 1'b0; valid_q <= 1'b0;
      cnt_q <= '0; bit_q <= '0; sh_q <= '0;
    end else begin
      sync_q  <= {sync_q[0], rxd_i};
      valid_q <= 1'b0;
      if (!busy_q) begin
        if (!rx) begin
          busy_q <= 1'b1;
          cnt_q  <= CW'(HALF);
          bit_q  <= '0;
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CW'(1);
      end else begin
        cnt_q <= CW'(CLK_DIV - 1);
        bit_q <= bit_q + 4'd1;
        if (bit_q == 4'd0) begin
          if (rx) busy_q <= 1'b0;       // glitch, not a start bit
        end else if (bit_q < 4'd9) begin
          sh_q <= {rx, sh_q[7:1]};
        end else begin
          busy_q  <= 1'b0;
          valid_q <= rx;                // drop on framing error
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = sh_q;
endmodule

// File: rtl/frame_xcvr.sv
module frame_xcvr
  import frame_xcvr_pkg::*;
#(
  parameter int unsigned CLK_DIV        = 200,
  parameter int unsigned PAYLOAD_BYTES  = 28,
  parameter int unsigned TIMEOUT_CYCLES = 100000,
  parameter int unsigned MAX_RETRY      = 2,
  parameter logic [7:0]  DELIM          = 8'h40
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [PAYLOAD_BYTES*8-1:0] payload_i,
  output logic                       txd_o,
  output logic                       drv_en_o,
  input  logic                       rxd_i,
  output logic                       done_o,
  output logic [1:0]                 status_o,
  output logic [PAYLOAD_BYTES*8-1:0] reply_o
);
  localparam int unsigned FRAME_BYTES = PAYLOAD_BYTES + 2;
  localparam int unsigned IW          = $clog2(FRAME_BYTES);
  localparam int unsigned TMAX        = (TIMEOUT_CYCLES > CLK_DIV) ? TIMEOUT_CYCLES : CLK_DIV;
  localparam int unsigned TW          = $clog2(TMAX + 1);
  localparam int unsigned RW          = $clog2(MAX_RETRY + 2);
  localparam logic [IW-1:0] LAST_IDX  = IW'(FRAME_BYTES - 1);

  xfer_state_e  state_q;
  xfer_status_e status_q;
  logic [IW-1:0] idx_q;
  logic [TW-1:0] tmr_q;
  logic [RW-1:0] retry_q;
  logic [7:0]    crc_q, tx_byte, rx_data;
  logic          kick_q, done_q, tx_done, rx_valid;
  logic [7:0]    pay_q   [PAYLOAD_BYTES];
  logic [7:0]    reply_q [PAYLOAD_BYTES];

  frame_xcvr_tx #(.CLK_DIV(CLK_DIV)) u_tx (
    .clk_i, .rst_ni, .send_i(kick_q), .data_i(tx_byte), .txd_o, .done_o(tx_done)
  );

  frame_xcvr_rx #(.CLK_DIV(CLK_DIV)) u_rx (
    .clk_i, .rst_ni, .rxd_i, .valid_o(rx_valid), .data_o(rx_data)
  );

  always_comb begin
    if (idx_q == '0)            tx_byte = DELIM;
    else if (idx_q == LAST_IDX) tx_byte = crc_q;
    else                        tx_byte = pay_q[idx_q - IW'(1)];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE; status_q <= XS_NONE; idx_q <= '0; tmr_q <= '0;
      retry_q <= '0; crc_q <= CRC_SEED; kick_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        FS_IDLE: if (start_i) begin
          state_q <= FS_SEND; idx_q <= '0; kick_q <= 1'b1;
          crc_q <= CRC_SEED; retry_q <= '0;
        end
        FS_SEND: begin
          if (kick_q) begin
            kick_q <= 1'b0;
            if (idx_q != '0 && idx_q != LAST_IDX) crc_q <= crc8_step(crc_q, tx_byte);
          end
          if (tx_done) begin
            if (idx_q == LAST_IDX) begin
              state_q <= FS_HOLD; tmr_q <= '0;
            end else begin
              idx_q <= idx_q + IW'(1); kick_q <= 1'b1;
            end
          end
        end
        FS_HOLD: begin  // keep driving one bit time past the last stop bit
          if (tmr_q == TW'(CLK_DIV - 1)) begin
            state_q <= FS_LISTEN; tmr_q <= '0; idx_q <= '0; crc_q <= CRC_SEED;
          end else begin
            tmr_q <= tmr_q + TW'(1);
          end
        end
        FS_LISTEN: begin
          tmr_q <= tmr_q + TW'(1);
          if (rx_valid && idx_q == LAST_IDX) begin
            done_q   <= 1'b1;
            status_q <= (rx_data == crc_q) ? XS_OK : XS_CRC_ERR;
            state_q  <= FS_IDLE;
          end else if (tmr_q == TW'(TIMEOUT_CYCLES - 1)) begin
            if (retry_q == RW'(MAX_RETRY)) begin
              done_q <= 1'b1; status_q <= XS_TIMEOUT; state_q <= FS_IDLE;
            end else begin
              retry_q <= retry_q + RW'(1); state_q <= FS_SEND;
              idx_q <= '0; kick_q <= 1'b1; crc_q <= CRC_SEED;
            end
          end else if (rx_valid) begin
            if (idx_q == '0) begin
              if (rx_data == DELIM) idx_q <= IW'(1);
            end else begin
              crc_q <= crc8_step(crc_q, rx_data);
              idx_q <= idx_q + IW'(1);
            end
          end
        end
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (state_q == FS_IDLE && start_i)
      for (int k = 0; k < PAYLOAD_BYTES; k++) pay_q[k] <= payload_i[8*k +: 8];
    if (state_q == FS_LISTEN && rx_valid && idx_q != '0 && idx_q != LAST_IDX)
      reply_q[idx_q - IW'(1)] <= rx_data;
  end

  for (genvar k = 0; k < PAYLOAD_BYTES; k++) begin : g_reply
    assign reply_o[8*k +: 8] = reply_q[k];
  end

  assign drv_en_o = (state_q == FS_SEND) || (state_q == FS_HOLD);
  assign done_o   = done_q;
  assign status_o = status_q;
endmodule

// File: rtl/frame_xcvr_checks.sv
module frame_xcvr_checks #(
  parameter int unsigned MAX_RETRY = 2,
  parameter int unsigned RW        = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          txd_o,
  input logic          drv_en_o,
  input logic          done_o,
  input logic [1:0]    status_o,
  input logic [RW-1:0] retry_q
);
  assert_line_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drv_en_o |-> txd_o);

  assert_done_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !drv_en_o);

  assert_retry_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_q <= RW'(MAX_RETRY));

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_status_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_o) |-> done_o);

  assert_done_coded_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> status_o != 2'd0);
endmodule

bind frame_xcvr frame_xcvr_checks #(.MAX_RETRY(MAX_RETRY), .RW(RW)) u_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .txd_o(txd_o), .drv_en_o(drv_en_o),
  .done_o(done_o), .status_o(status_o), .retry_q(retry_q)
);

// File: tb/frame_xcvr_bench.sv
module frame_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 8;
  localparam int PAY = 28;
  localparam int TMO = 4000;
  localparam int PW  = PAY * 8;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rxd = 1'b1;
  logic [PW-1:0] payload = '0;
  logic txd, drv_en, done;
  logic [1:0] status;
  logic [PW-1:0] reply;

  int checks = 0, errors = 0, done_cnt = 0;
  longint cyc = 0;

  typedef struct {
    logic [1:0]    st;
    logic [PW-1:0] rep;
    bit            use_rep;
    string         req;
  } exp_t;
  exp_t sb_q[$];

  frame_xcvr #(.CLK_DIV(DIV), .PAYLOAD_BYTES(PAY), .TIMEOUT_CYCLES(TMO), .MAX_RETRY(2)) u_frame_xcvr (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .payload_i(payload),
    .txd_o(txd), .drv_en_o(drv_en), .rxd_i(rxd),
    .done_o(done), .status_o(status), .reply_o(reply)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [PW-1:0] d);
    logic [7:0] c = 8'hFF;
    for (int k = 0; k < PAY; k++) begin
      c ^= d[8*k +: 8];
      for (int j = 0; j < 8; j++) c = c[7] ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
    end
    return c;
  endfunction

  function automatic logic [PW-1:0] ramp(input logic [7:0] seed, input logic [7:0] step);
    logic [PW-1:0] v;
    for (int k = 0; k < PAY; k++) v[8*k +: 8] = seed + 8'(k) * step;
    return v;
  endfunction

  // monitor: pops the scoreboard on each done pulse
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && done) begin
      done_cnt++;
      if (sb_q.size() == 0) check(1'b0, "R9", "unexpected done", PW'(status), '0);
      else begin
        e = sb_q.pop_front();
        check(status == e.st, e.req, "status", PW'(status), PW'(e.st));
        if (e.use_rep) check(reply == e.rep, "R5", "reply payload", reply, e.rep);
      end
    end
  end

  task automatic get_byte(output logic [7:0] b, output longint t0, output bit drv);
    while (txd) @(negedge clk);
    t0 = cyc; drv = drv_en;
    repeat (DIV/2) @(negedge clk);
    for (int j = 0; j < 8; j++) begin
      repeat (DIV) @(negedge clk);
      b[j] = txd;
    end
    repeat (DIV) @(negedge clk);
  endtask

  task automatic get_frame(input logic [PW-1:0] pay, output longint last_t0);
    logic [7:0] b, e;
    longint t0;
    bit drv, body_ok = 1, drv_ok = 1;
    logic [7:0] bad_a = 0, bad_e = 0, crc_b = 0;
    for (int k = 0; k < PAY + 2; k++) begin
      get_byte(b, t0, drv);
      if (!drv) drv_ok = 0;
      if (k == PAY + 1) crc_b = b;
      else begin
        e = (k == 0) ? 8'h40 : pay[8*(k-1) +: 8];
        if (b != e && body_ok) begin body_ok = 0; bad_a = b; bad_e = e; end
      end
    end
    last_t0 = t0;
    check(body_ok, "R2", "frame delimiter/payload byte", PW'(bad_a), PW'(bad_e));
    check(crc_b == ref_crc(pay), "R3", "frame crc byte", PW'(crc_b), PW'(ref_crc(pay)));
    check(drv_ok, "R4", "driver enabled at start bits", PW'(drv_ok), PW'(1));
  endtask

  task automatic send_byte(input logic [7:0] b);
    rxd = 1'b0; repeat (DIV) @(negedge clk);
    for (int j = 0; j < 8; j++) begin rxd = b[j]; repeat (DIV) @(negedge clk); end
    rxd = 1'b1; repeat (DIV) @(negedge clk);
  endtask

  task automatic send_frame(input logic [PW-1:0] rep, input bit good, input bit junk);
    if (junk) send_byte(8'h55);
    send_byte(8'h40);
    for (int k = 0; k < PAY; k++) send_byte(rep[8*k +: 8]);
    send_byte(ref_crc(rep) ^ (good ? 8'h00 : 8'h01));
  endtask

  // mode: 0 valid reply, 1 bad crc, 2 no reply, 3 junk before a valid reply
  task automatic run_case(input logic [PW-1:0] pay, input logic [PW-1:0] rep, input int mode,
                          input int frames, input logic [1:0] exp_st,
                          input string req, input string qreq);
    exp_t e;
    int d0;
    longint t0;
    bit quiet = 1;
    e.st = exp_st; e.rep = rep; e.use_rep = (exp_st == 2'd1); e.req = req;
    sb_q.push_back(e);
    d0 = done_cnt;
    payload = pay; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    payload = ~pay;  // R7: resends must use the captured payload
    for (int f = 0; f < frames; f++) begin
      get_frame(pay, t0);
      if (f == 0) begin  // R9: start during an exchange is ignored
        start = 1'b1; @(negedge clk); start = 1'b0;
      end
      while (cyc < t0 + 10*DIV + DIV/2) @(negedge clk);
      check(drv_en == 1'b1, "R4", "driver held after last stop bit", PW'(drv_en), PW'(1));
      while (cyc < t0 + 12*DIV) @(negedge clk);
      check(drv_en == 1'b0, "R4", "driver released", PW'(drv_en), PW'(0));
      if (f == frames - 1 && mode != 2) send_frame(rep, mode != 1, mode == 3);
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (600) begin
      @(negedge clk);
      if (drv_en || !txd) quiet = 0;
    end
    check(quiet, qreq, "no further frame after done", PW'(quiet), PW'(1));
  endtask

  bit finished = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] rep_delims;
    for (int k = 0; k < PAY; k++) rep_delims[8*k +: 8] = (k % 3 == 0) ? 8'h40 : 8'(k);
    repeat (3) @(negedge clk);
    // R1 reset state
    check(txd == 1'b1, "R1", "txd in reset", PW'(txd), PW'(1));
    check(drv_en == 1'b0, "R1", "drv_en in reset", PW'(drv_en), PW'(0));
    check(done == 1'b0 && status == 2'd0, "R1", "done/status in reset", PW'({done, status}), '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    run_case(ramp(8'h01, 8'h01), rep_delims, 0, 1, 2'd1, "R5", "R9");
    run_case({PW{1'b0}}, ramp(8'h80, 8'h07), 1, 1, 2'd2, "R6", "R6");
    run_case({PW{1'b1}}, ramp(8'h10, 8'h0D), 3, 1, 2'd1, "R5", "R9");
    run_case(ramp(8'hA5, 8'h11), ramp(8'h00, 8'h00), 2, 3, 2'd3, "R7", "R7");
    run_case(ramp(8'h3C, 8'hF3), {PW{1'b1}}, 0, 2, 2'd1, "R8", "R8");

    check(sb_q.size() == 0, "R9", "every exchange completed once", PW'(sb_q.size()), '0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule